// File: doc/BRIEF.md
# Serial Memory Write-Guard Controller

This block is the command front end of a 512-byte serial nonvolatile memory. It listens on a four-wire serial bus in clock-polarity-0, clock-phase-0 timing and decodes four one-byte commands: latch-set, latch-clear, status read and status write. It keeps an 8-bit status byte. That byte holds a write-enable latch and a two-bit range-protect code. Everything else about the memory (the array, the data read and data write commands, nonvolatile storage of the code) lives outside the block. Here the code is kept in a plain register.

In the same cycle that a memory write request is presented, the block answers with a grant or a block. The answer takes three things into account: the active-low write-protect pin, the latch, and whether the 9-bit address lies in the range that the code protects. Requests carry only a valid bit and an address. The decision is combinational, so the requester is never held off. A request counts as accepted in every cycle its valid bit is high. No ready signal exists, because the block applies no back-pressure.

A command is acted on only when chip select rises after a whole number of bytes. All latch and code changes occur in the clock cycle after that rising edge is seen.

Top module: `spi_wp_ctrl`

## Requirements
- R1: Incoming bits are taken on rising serial-clock edges while chip select is low. Within a byte the first bit is the most significant. Outgoing bits change only after falling serial-clock edges, most significant bit first.
- R2: After the status-read opcode 05h, the next byte shifted out is the status byte: bit 3 = protect code high, bit 2 = protect code low, bit 1 = latch, and bits 7..4 and bit 0 = 0. Any further bytes in the same transaction shift out as 00h.
- R3: Opcode 06h sets the latch and opcode 04h clears it. Each takes effect when chip select rises.
- R4: Opcode 01h followed by a data byte copies data bits 3:2 into the code and clears the latch. This happens only when the pin is high and the latch is set at the moment chip select rises. All other data bits, including bit 1, have no effect.
- R5: A status write made with the pin low, or with the latch clear, changes neither the code nor the latch.
- R6: If chip select rises part-way through a byte, the transaction is dropped. An opcode other than the four listed is ignored, together with the rest of its transaction. Opcode 01h sent without a data byte does nothing.
- R7: Code 00 protects no address, 01 protects 180h-1FFh, 10 protects 100h-1FFh, and 11 protects 000h-1FFh.
- R8: A request is granted only when the pin is high, the latch is set and the address is unprotected. Any other valid request is blocked. With no valid request, both grant and block stay low.
- R9: A granted request clears the latch on the next rising edge of chip select.
- R10: After reset the latch is 0 and the code is 00. The serial output enable equals the inverse of chip select, and the serial output is held at 0 while that enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial pins are sampled with it |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output enable for the miso pad driver |
| wp_n | input | 1 | Active-low hardware write protect |
| req_valid | input | 1 | Memory write request present |
| req_addr | input | 9 | Byte address of the memory write request |
| req_grant | output | 1 | Request may write the array |
| req_block | output | 1 | Request is refused |

## Verification
A wrong latch or code value has two visible effects. It shows in the very cycle a memory request is presented, as a grant where a block was due or the reverse. It also shows in the status byte returned by the next status read. A mis-timed output shifter corrupts the status byte bit by bit within that read. A decode or abort fault becomes visible at the first request or status read after chip select rises. The bench therefore follows every transaction with a status read, and it sweeps request addresses around each range boundary for every code.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;

  localparam logic [7:0] OP_LATCH_SET = 8'h06;
  localparam logic [7:0] OP_LATCH_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD   = 8'h05;
  localparam logic [7:0] OP_STAT_WR   = 8'h01;

  // field positions the status read and status write decode
  localparam int CODE_HI_BIT = 3;
  localparam int CODE_LO_BIT = 2;
  localparam int LATCH_BIT   = 1;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_SET,
    ACT_CLR,
    ACT_WSTAT
  } act_e;

  typedef enum logic [1:0] {
    PH_OPCODE,
    PH_DATA,
    PH_SKIP
  } phase_e;

endpackage

// File: rtl/spi_wp_shifter.sv
module spi_wp_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              aligned,
  output logic              cs_rise,
  output logic              miso_q
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic              sck_q, cs_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              sck_up, sck_dn;

  assign sck_up   = ~cs_n & sck & ~sck_q;
  assign sck_dn   = ~cs_n & ~sck & sck_q;
  assign cs_rise  = cs_n & ~cs_q;
  assign aligned  = (bit_cnt == '0);
  assign byte_stb = sck_up & (bit_cnt == LAST);
  assign rx_byte  = {rx_sh[BYTE_W-2:0], mosi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else if (cs_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else if (sck_up) begin
      rx_sh   <= rx_byte;
      bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      miso_q <= 1'b0;
    end else if (cs_n) begin
      tx_sh  <= '0;
      miso_q <= 1'b0;
    end else if (tx_load) begin
      tx_sh  <= tx_byte;
    end else if (sck_dn) begin
      miso_q <= tx_sh[BYTE_W-1];
      tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
    end
  end

  // R1: output bit moves only after a falling serial edge inside a transaction
  a_r1_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$stable(miso_q)) |-> $past(sck_q && !sck));

endmodule

// File: rtl/spi_wp_cmd.sv
module spi_wp_cmd
  import spi_wp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              aligned,
  input  logic              cs_rise,
  input  logic              wp_n,
  input  logic              mem_grant,
  output logic              wel,
  output logic [CODE_W-1:0] code,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_byte
);

  phase_e            phase;
  act_e              act;
  logic [CODE_W-1:0] new_code;
  logic              granted;

  always_comb begin
    tx_byte = '0;
    tx_byte[CODE_HI_BIT:CODE_LO_BIT] = code;
    tx_byte[LATCH_BIT] = wel;
  end

  assign tx_load = byte_stb && (phase == PH_OPCODE) && (rx_byte == OP_STAT_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_OPCODE;
      act      <= ACT_NONE;
      new_code <= '0;
    end else if (cs_rise) begin
      phase    <= PH_OPCODE;
      act      <= ACT_NONE;
    end else if (byte_stb) begin
      unique case (phase)
        PH_OPCODE: begin
          phase <= PH_SKIP;
          if (rx_byte == OP_LATCH_SET)      act <= ACT_SET;
          else if (rx_byte == OP_LATCH_CLR) act <= ACT_CLR;
          else if (rx_byte == OP_STAT_WR)   phase <= PH_DATA;
        end
        PH_DATA: begin
          act      <= ACT_WSTAT;
          new_code <= rx_byte[CODE_HI_BIT:CODE_LO_BIT];
          phase    <= PH_SKIP;
        end
        default: phase <= PH_SKIP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         granted <= 1'b0;
    else if (cs_rise)   granted <= 1'b0;
    else if (mem_grant) granted <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      code <= '0;
    end else if (cs_rise) begin
      if (aligned) begin
        unique case (act)
          ACT_SET:   wel <= 1'b1;
          ACT_CLR:   wel <= 1'b0;
          ACT_WSTAT: if (wp_n && wel) begin
            code <= new_code;
            wel  <= 1'b0;
          end
          default: ;
        endcase
      end
      if (granted || mem_grant) wel <= 1'b0;
    end
  end

  // R3: the latch changes only as a result of chip select rising
  a_r3_latch_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wel) |-> $past(cs_rise));
  // R5: the code changes only if the pin was high and the latch was set
  a_r5_code_needs_pin_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code) |-> $past(wp_n && wel));
  // R4: a code update always leaves the latch clear
  a_r4_code_write_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code) |-> !wel);

endmodule

// File: rtl/spi_wp_guard.sv
module spi_wp_guard #(
  parameter int ADDR_W = 9,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              wp_n,
  input  logic              wel,
  input  logic [CODE_W-1:0] code,
  output logic              grant,
  output logic              block
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] QUARTER_BASE = ADDR_W'((DEPTH / 4) * 3);
  localparam logic [ADDR_W-1:0] HALF_BASE    = ADDR_W'(DEPTH / 2);

  logic in_range;

  always_comb begin
    unique case (code)
      2'b00:   in_range = 1'b0;
      2'b01:   in_range = (req_addr >= QUARTER_BASE);
      2'b10:   in_range = (req_addr >= HALF_BASE);
      default: in_range = 1'b1;
    endcase
  end

  assign grant = req_valid & wp_n & wel & ~in_range;
  assign block = req_valid & ~grant;

  // R7: with every address protected no request may ever pass
  a_r7_full_code_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 2'b11) |-> !grant);
  // R8: a low pin refuses every valid request
  a_r8_pin_low_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && req_valid) |-> block);

endmodule

// File: rtl/spi_wp_ctrl.sv
module spi_wp_ctrl
  import spi_wp_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BYTE_W = 8,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic              wp_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_grant,
  output logic              req_block
);

  logic              byte_stb, aligned, cs_rise, tx_load, miso_q, wel;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  logic [CODE_W-1:0] code;

  spi_wp_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .tx_load(tx_load), .tx_byte(tx_byte), .byte_stb(byte_stb),
    .rx_byte(rx_byte), .aligned(aligned), .cs_rise(cs_rise), .miso_q(miso_q)
  );

  spi_wp_cmd #(.BYTE_W(BYTE_W), .CODE_W(CODE_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .rx_byte(rx_byte),
    .aligned(aligned), .cs_rise(cs_rise), .wp_n(wp_n), .mem_grant(req_grant),
    .wel(wel), .code(code), .tx_load(tx_load), .tx_byte(tx_byte)
  );

  spi_wp_guard #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .wp_n(wp_n), .wel(wel), .code(code), .grant(req_grant), .block(req_block)
  );

  assign miso_oe = ~cs_n;
  assign miso    = miso_q & ~cs_n;

  // R10: output stays quiet while the pad driver is disabled
  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso);

endmodule

// File: tb/test_spi_wp_ctrl.sv
module test_spi_wp_ctrl;

  logic       clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic       wp_n = 1'b1, req_valid = 1'b0;
  logic [8:0] req_addr = '0;
  logic       miso, miso_oe, req_grant, req_block;

  spi_wp_ctrl i_spi_wp_ctrl (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .wp_n(wp_n), .req_valid(req_valid),
    .req_addr(req_addr), .req_grant(req_grant), .req_block(req_block)
  );

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit       m_wel = 1'b0, m_gflag = 1'b0;
  bit [1:0] m_code = 2'b00;

  logic [7:0] ops[$];
  logic [8:0] reqs[$];
  logic [7:0] rsp[$];
  int         granted_cnt;

  function automatic bit m_prot(bit [1:0] c, bit [8:0] a);
    case (c)
      2'd0:    return 1'b0;
      2'd1:    return a >= 9'h180;
      2'd2:    return a >= 9'h100;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit m_grant();
    return req_valid && wp_n && m_wel && !m_prot(m_code, req_addr);
  endfunction

  function automatic logic [7:0] m_status();
    return {4'b0000, m_code, m_wel, 1'b0};
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R8 grant", int'(req_grant), int'(m_grant()));
      check("R8 block", int'(req_block), int'(req_valid && !m_grant()));
      check("R10 oe", int'(miso_oe), int'(!cs_n));
      if (!miso_oe) check("R10 quiet", int'(miso), 0);
    end
  end

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      tick(2);
      rx[i] = miso;
      sck = 1'b1;
      tick(2);
      sck = 1'b0;
    end
  endtask

  task automatic run(int extra_bits);
    logic [7:0] rx, st0;
    st0 = m_status();
    rsp.delete();
    cs_n = 1'b0;
    tick(2);
    foreach (ops[i]) begin
      xfer(ops[i], rx);
      rsp.push_back(rx);
    end
    foreach (reqs[i]) begin
      req_addr = reqs[i];
      req_valid = 1'b1;
      #5;
      if (m_grant()) begin
        m_gflag = 1'b1;
        granted_cnt++;
      end
      check("R7 range decision", int'(req_grant), int'(m_grant()));
      tick(1);
      req_valid = 1'b0;
    end
    for (int i = 0; i < extra_bits; i++) begin
      mosi = 1'b1;
      tick(2);
      sck = 1'b1;
      tick(2);
      sck = 1'b0;
    end
    tick(2);
    cs_n = 1'b1;
    tick(1);
    if (extra_bits == 0 && ops.size() > 0) begin
      case (ops[0])
        8'h06: m_wel = 1'b1;
        8'h04: m_wel = 1'b0;
        8'h01: if (ops.size() >= 2 && wp_n && m_wel) begin
          m_code = ops[1][3:2];
          m_wel = 1'b0;
        end
        default: ;
      endcase
    end
    if (m_gflag) begin
      m_wel = 1'b0;
      m_gflag = 1'b0;
    end
    tick(2);
    if (ops.size() >= 2 && ops[0] == 8'h05) begin
      check("R1/R2 status byte MSB first", int'(rsp[1]), int'(st0));
      if (ops.size() >= 3) check("R2 trailing byte", int'(rsp[2]), 0);
    end
    ops.delete();
    reqs.delete();
  endtask

  task automatic cmd(input logic [7:0] op);
    ops.push_back(op);
    run(0);
  endtask

  task automatic wstat(input logic [7:0] d);
    ops.push_back(8'h01);
    ops.push_back(d);
    run(0);
  endtask

  task automatic rstat(string tag, input logic [7:0] lit);
    ops.push_back(8'h05);
    ops.push_back(8'h00);
    run(0);
    check(tag, int'(rsp[1]), int'(lit));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    check("R10 oe after reset", int'(miso_oe), 0);
    rstat("R10 reset status", 8'h00);

    cmd(8'h06);
    rstat("R3 latch set", 8'h02);
    ops.push_back(8'h05); ops.push_back(8'h00); ops.push_back(8'h00);
    run(0);
    cmd(8'h04);
    rstat("R3 latch clear", 8'h00);

    cmd(8'h06);
    wstat(8'hFF);
    rstat("R4 write code fixed bits latch cleared", 8'h0C);

    wstat(8'h00);
    rstat("R5 no latch ignored", 8'h0C);

    wp_n = 1'b0;
    cmd(8'h06);
    wstat(8'h00);
    rstat("R5 pin low ignored", 8'h0E);
    reqs.push_back(9'h000); reqs.push_back(9'h0FF);
    run(0);
    rstat("R8 pin low blocked keeps latch", 8'h0E);
    wp_n = 1'b1;

    wstat(8'h06);
    rstat("R4 code 01 data bit1 ignored", 8'h04);

    cmd(8'h04);
    ops.push_back(8'h06);
    run(3);
    rstat("R6 partial byte aborts", 8'h04);
    run(5);
    ops.push_back(8'hAB); ops.push_back(8'h06);
    run(0);
    rstat("R6 unknown opcode ignored", 8'h04);
    cmd(8'h06);
    cmd(8'h01);
    rstat("R6 bare status write", 8'h06);

    for (int c = 0; c < 4; c++) begin
      cmd(8'h06);
      wstat(8'(c << 2));
      cmd(8'h06);
      granted_cnt = 0;
      reqs.push_back(9'h000); reqs.push_back(9'h0FF); reqs.push_back(9'h100);
      reqs.push_back(9'h17F); reqs.push_back(9'h180); reqs.push_back(9'h1FF);
      run(0);
      check("R7 grants per code", granted_cnt, (c == 0) ? 6 : (c == 1) ? 4 : (c == 2) ? 2 : 0);
      rstat("R9 latch after requests", (c == 3) ? 8'h0E : 8'(c << 2));
    end

    cmd(8'h04);
    reqs.push_back(9'h000);
    run(0);
    rstat("R8 latch clear refuses", 8'h0C);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule